// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block is a watchdog timer with a small register interface. Once it is enabled, a counter advances on every pulse of a slow tick input. When the counter reaches the programmed timeout, the block raises a reset request. Software keeps the system alive by writing a refresh key to the counter register. Any other value written to that register has no effect.

Changing the configuration needs a second key, the unlock key, which opens a short window in which the control and timeout registers accept writes. Each key can be given in one of two command modes:

- as a single 32-bit word, or
- as two 16-bit halves written one straight after the other.

The control register can also forbid any later unlock. Once that happens, the configuration stays frozen until the next reset.

A reset request is a one-clock pulse. After it, the counter stays frozen until the block itself is reset. The tick is normally a 1 kHz strobe, so a timeout of N seconds is programmed as N×1000 ticks. The reset value of the timeout corresponds to 128 seconds.

Top module: `keyguard_wdt`

## Requirements
- R1: After reset the control word reads 0x0000_0020 (only update-allow set), the timeout reads TOUT_MAX, the counter reads 0 and the reset request is low. Registers sit at byte offsets 0x0 (control), 0x4 (counter) and 0x8 (timeout). The control bits are: bit 13 = 32-bit command mode, bit 11 = unlocked, bit 10 = reconfiguration done, bit 7 = enable, bit 5 = update-allow.
- R2: In 32-bit command mode, writing 0xD928C520 to the counter register unlocks the block, and control bit 11 reads 1.
- R3: In 16-bit command mode, two consecutive bus writes to the counter register whose low halves are 0xC520 and then 0xD928 unlock the block. If the second write is any other write, or any other write comes in between, the pending half is dropped.
- R4: A refresh clears the counter to 0. In 32-bit mode the refresh is the word 0xB480A602. In 16-bit mode it is the low half 0xA602 followed directly by 0xB480. Any other counter-register write leaves the counter unchanged.
- R5: The unlocked state lasts UNLOCK_WIN clocks. A control or timeout write made while locked is ignored.
- R6: A control write while unlocked loads command mode (bit 13), enable (bit 7) and update-allow (bit 5). It also ends the unlocked state and sets bit 10. A timeout write while unlocked loads the timeout and leaves the block unlocked.
- R7: Once update-allow has been cleared, unlock keys are ignored until the next reset.
- R8: While enabled, the counter increments by one on each clock with tick high. While disabled, it does not count.
- R9: While enabled, a counter that has reached or passed the timeout raises the reset request for exactly one clock, one clock later. From then on the counter stays frozen, and refresh keys are ignored, until reset.
- R10: Reads with the read strobe low, or of any offset other than 0x0, 0x4 and 0x8, return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | ADDR_W | Byte offset of the register accessed |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe, one access per clock |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, combinational from address and read strobe |
| tick | input | 1 | Timebase strobe, one clock wide per tick |
| wdog_rst_req | output | 1 | One-clock reset request on timeout |

## Verification
The bench builds the block with UNLOCK_WIN = 16, so the unlock window can be seen expiring within a few tens of cycles. The other parameters keep their defaults. The default TOUT_MAX is checked only as the reset value. A 20-tick timeout is then programmed through the bus, so the firing path, the single-cycle pulse and the frozen counter are all reached in a short run. The tick is driven on chosen clocks, which makes the exact clock in which the count reaches the timeout known in advance.

// File: rtl/kgw_pkg.sv
package kgw_pkg;
  localparam int DATA_W    = 32;
  localparam int OFF_CTRL  = 0;
  localparam int OFF_CNT   = 4;
  localparam int OFF_TOVAL = 8;

  // control word bit positions
  localparam int B_MODE = 13;
  localparam int B_UNL  = 11;
  localparam int B_RCS  = 10;
  localparam int B_EN   = 7;
  localparam int B_UA   = 5;

  // key table: index 0 opens configuration, index 1 restarts the count
  localparam int NKEY        = 2;
  localparam int KEY_UNLOCK  = 0;
  localparam int KEY_REFRESH = 1;
  localparam logic [NKEY-1:0][15:0] KEY_LO = {16'hA602, 16'hC520};
  localparam logic [NKEY-1:0][15:0] KEY_HI = {16'hB480, 16'hD928};
endpackage

// File: rtl/kgw_rst_sync.sv
module kgw_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/kgw_keyseq.sv
module kgw_keyseq
  import kgw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_any,
  input  logic              wr_cnt,
  input  logic [DATA_W-1:0] wdata,
  input  logic              mode32,
  output logic [NKEY-1:0]   hit
);
  for (genvar k = 0; k < NKEY; k++) begin : g_key
    logic pend_q, pend_d, hit32, hit16;

    assign hit32  = wr_cnt && (wdata == {KEY_HI[k], KEY_LO[k]});
    assign hit16  = wr_cnt && pend_q && (wdata[15:0] == KEY_HI[k]);
    assign hit[k] = mode32 ? hit32 : hit16;

    // any bus write re-decides the pending first half
    always_comb begin
      pend_d = pend_q;
      if (wr_any) pend_d = !mode32 && wr_cnt && (wdata[15:0] == KEY_LO[k]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q <= 1'b0;
      else        pend_q <= pend_d;
    end
  end
endmodule

// File: rtl/kgw_lock.sv
module kgw_lock
  import kgw_pkg::*;
#(
  parameter int CNT_W      = 32,
  parameter int UNLOCK_WIN = 128,
  parameter int TOUT_MAX   = 128000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              unl_hit,
  input  logic              wr_ctl,
  input  logic              wr_to,
  input  logic [DATA_W-1:0] wdata,
  output logic              unlocked,
  output logic              rcs,
  output logic              mode32,
  output logic              en,
  output logic              ua,
  output logic [CNT_W-1:0]  toval
);
  localparam int WIN_W = (UNLOCK_WIN > 1) ? $clog2(UNLOCK_WIN) : 1;

  logic             unl_q, unl_d, rcs_q, rcs_d, m32_q, m32_d, en_q, en_d, ua_q, ua_d;
  logic [WIN_W-1:0] win_q, win_d;
  logic [CNT_W-1:0] to_q, to_d;

  always_comb begin
    unl_d = unl_q;
    win_d = win_q;
    rcs_d = rcs_q;
    m32_d = m32_q;
    en_d  = en_q;
    ua_d  = ua_q;
    to_d  = to_q;
    if (unl_hit && ua_q) begin
      unl_d = 1'b1;
      win_d = WIN_W'(UNLOCK_WIN - 1);
      rcs_d = 1'b0;
    end else if (unl_q) begin
      if (wr_ctl) begin
        unl_d = 1'b0;
        rcs_d = 1'b1;
      end else if (win_q == '0) begin
        unl_d = 1'b0;
      end else begin
        win_d = win_q - 1'b1;
      end
    end
    if (unl_q && wr_ctl) begin
      m32_d = wdata[B_MODE];
      en_d  = wdata[B_EN];
      ua_d  = wdata[B_UA];
    end
    if (unl_q && wr_to) to_d = wdata[CNT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      unl_q <= 1'b0;
      win_q <= '0;
      rcs_q <= 1'b0;
      m32_q <= 1'b0;
      en_q  <= 1'b0;
      ua_q  <= 1'b1;
      to_q  <= CNT_W'(TOUT_MAX);
    end else begin
      unl_q <= unl_d;
      win_q <= win_d;
      rcs_q <= rcs_d;
      m32_q <= m32_d;
      en_q  <= en_d;
      ua_q  <= ua_d;
      to_q  <= to_d;
    end
  end

  assign unlocked = unl_q;
  assign rcs      = rcs_q;
  assign mode32   = m32_q;
  assign en       = en_q;
  assign ua       = ua_q;
  assign toval    = to_q;
endmodule

// File: rtl/kgw_count.sv
module kgw_count #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             tick,
  input  logic             ref_hit,
  input  logic [CNT_W-1:0] toval,
  output logic [CNT_W-1:0] cnt,
  output logic             fired,
  output logic             rst_req
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             fired_q, fired_d, req_q, req_d;

  always_comb begin
    cnt_d   = cnt_q;
    fired_d = fired_q;
    req_d   = 1'b0;
    if (!fired_q) begin
      if (en && (cnt_q >= toval)) begin
        fired_d = 1'b1;
        req_d   = 1'b1;
      end else if (ref_hit) begin
        cnt_d = '0;
      end else if (en && tick) begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      fired_q <= 1'b0;
      req_q   <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      fired_q <= fired_d;
      req_q   <= req_d;
    end
  end

  assign cnt     = cnt_q;
  assign fired   = fired_q;
  assign rst_req = req_q;
endmodule

// File: rtl/keyguard_wdt.sv
module keyguard_wdt
  import kgw_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int CNT_W      = 32,
  parameter int UNLOCK_WIN = 128,
  parameter int TOUT_MAX   = 128000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              tick,
  output logic              wdog_rst_req
);
  logic             srst_n;
  logic             wr_ctl, wr_cnt, wr_to;
  logic [NKEY-1:0]  key_hit;
  logic             unl_hit, ref_hit;
  logic             unlocked, rcs, mode32, en, ua, fired;
  logic [CNT_W-1:0] toval, cnt;
  logic [DATA_W-1:0] ctrl_word;

  kgw_rst_sync u_rst (.clk(clk), .arst_n(rst_n), .srst_n(srst_n));

  assign wr_ctl = bus_wr && (bus_addr == ADDR_W'(OFF_CTRL));
  assign wr_cnt = bus_wr && (bus_addr == ADDR_W'(OFF_CNT));
  assign wr_to  = bus_wr && (bus_addr == ADDR_W'(OFF_TOVAL));

  kgw_keyseq u_key (
    .clk(clk), .rst_n(srst_n), .wr_any(bus_wr), .wr_cnt(wr_cnt),
    .wdata(bus_wdata), .mode32(mode32), .hit(key_hit)
  );

  assign unl_hit = key_hit[KEY_UNLOCK];
  assign ref_hit = key_hit[KEY_REFRESH];

  kgw_lock #(.CNT_W(CNT_W), .UNLOCK_WIN(UNLOCK_WIN), .TOUT_MAX(TOUT_MAX)) u_lock (
    .clk(clk), .rst_n(srst_n), .unl_hit(unl_hit), .wr_ctl(wr_ctl), .wr_to(wr_to),
    .wdata(bus_wdata), .unlocked(unlocked), .rcs(rcs), .mode32(mode32),
    .en(en), .ua(ua), .toval(toval)
  );

  kgw_count #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(srst_n), .en(en), .tick(tick), .ref_hit(ref_hit),
    .toval(toval), .cnt(cnt), .fired(fired), .rst_req(wdog_rst_req)
  );

  always_comb begin
    ctrl_word         = '0;
    ctrl_word[B_MODE] = mode32;
    ctrl_word[B_UNL]  = unlocked;
    ctrl_word[B_RCS]  = rcs;
    ctrl_word[B_EN]   = en;
    ctrl_word[B_UA]   = ua;
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      case (bus_addr)
        ADDR_W'(OFF_CTRL):  bus_rdata = ctrl_word;
        ADDR_W'(OFF_CNT):   bus_rdata = DATA_W'(cnt);
        ADDR_W'(OFF_TOVAL): bus_rdata = DATA_W'(toval);
        default:            bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/kgw_chk.sv
module kgw_chk #(
  parameter int CNT_W      = 32,
  parameter int UNLOCK_WIN = 128
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_ctl,
  input logic             wr_to,
  input logic             unl_hit,
  input logic             ref_hit,
  input logic             unlocked,
  input logic             en,
  input logic             ua,
  input logic             fired,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] toval,
  input logic             rst_req
);
  localparam int RUN_W = $clog2(UNLOCK_WIN + 1) + 1;
  logic [RUN_W-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          run_q <= '0;
    else if (unlocked && !(unl_hit && ua)) run_q <= run_q + 1'b1;
    else                                 run_q <= '0;
  end

  a_r5_window_len: assert property (@(posedge clk) disable iff (!rst_n)
    unlocked |-> (run_q < RUN_W'(UNLOCK_WIN)));
  a_r5_locked_ctl: assert property (@(posedge clk) disable iff (!rst_n)
    (!unlocked && wr_ctl) |=> ($stable(en) && $stable(ua)));
  a_r5_locked_to: assert property (@(posedge clk) disable iff (!rst_n)
    (!unlocked && wr_to) |=> $stable(toval));
  a_r6_ctl_closes: assert property (@(posedge clk) disable iff (!rst_n)
    (unlocked && wr_ctl) |=> !unlocked);
  a_r7_stay_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (!ua && !unlocked) |=> !unlocked);
  a_r4_refresh_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_hit && !fired && !(en && cnt >= toval)) |=> (cnt == '0));
  a_r8_idle_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !ref_hit) |=> $stable(cnt));
  a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);
  a_r9_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    fired |=> $stable(cnt));
endmodule

bind keyguard_wdt kgw_chk #(.CNT_W(CNT_W), .UNLOCK_WIN(UNLOCK_WIN)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_ctl(wr_ctl), .wr_to(wr_to), .unl_hit(unl_hit),
  .ref_hit(ref_hit), .unlocked(unlocked), .en(en), .ua(ua), .fired(fired),
  .cnt(cnt), .toval(toval), .rst_req(wdog_rst_req)
);

// File: tb/sim_keyguard_wdt.sv
module sim_keyguard_wdt;
  localparam int WIN = 16;
  localparam int TMAX = 128000;

  logic        clk;
  logic        rst_n;
  logic [3:0]  b_addr;
  logic [31:0] b_wdata;
  logic        b_wr, b_rd, b_tick;
  logic [31:0] rdata;
  logic        rst_req;

  int nchk = 0;
  int nfail = 0;
  bit cmp_en = 0;
  bit done = 0;

  keyguard_wdt #(.UNLOCK_WIN(WIN)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(b_addr), .bus_wdata(b_wdata),
    .bus_wr(b_wr), .bus_rd(b_rd), .bus_rdata(rdata), .tick(b_tick),
    .wdog_rst_req(rst_req)
  );

  initial clk = 0;
  always #10 clk = ~clk;

  // behavioural reference for the reset request
  int m_cnt, m_to, m_win, m_pend;
  bit m_c32, m_unl, m_rcs, m_en, m_ua, m_fired, m_rst;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_to = TMAX; m_win = 0; m_pend = 0;
      m_c32 = 0; m_unl = 0; m_rcs = 0; m_en = 0; m_ua = 1; m_fired = 0; m_rst = 0;
    end else begin
      bit wc, wctl, wto, uh, rh, n_unl, n_rcs, n_c32, n_en, n_ua, n_fired, n_rst;
      int n_cnt, n_to, n_win, n_pend;
      wc   = b_wr && b_addr == 4;
      wctl = b_wr && b_addr == 0;
      wto  = b_wr && b_addr == 8;
      if (m_c32) begin
        uh = wc && b_wdata == 32'hD928C520;
        rh = wc && b_wdata == 32'hB480A602;
      end else begin
        uh = wc && m_pend == 1 && b_wdata[15:0] == 16'hD928;
        rh = wc && m_pend == 2 && b_wdata[15:0] == 16'hB480;
      end
      n_pend = m_pend;
      if (b_wr) n_pend = (!m_c32 && wc && b_wdata[15:0] == 16'hC520) ? 1 :
                         (!m_c32 && wc && b_wdata[15:0] == 16'hA602) ? 2 : 0;
      n_cnt = m_cnt; n_fired = m_fired; n_rst = 0;
      if (!m_fired) begin
        if (m_en && m_cnt >= m_to) begin n_fired = 1; n_rst = 1; end
        else if (rh) n_cnt = 0;
        else if (m_en && b_tick) n_cnt = m_cnt + 1;
      end
      n_unl = m_unl; n_win = m_win; n_rcs = m_rcs;
      n_c32 = m_c32; n_en = m_en; n_ua = m_ua; n_to = m_to;
      if (uh && m_ua) begin n_unl = 1; n_win = WIN - 1; n_rcs = 0; end
      else if (m_unl) begin
        if (wctl) begin n_unl = 0; n_rcs = 1; end
        else if (m_win == 0) n_unl = 0;
        else n_win = m_win - 1;
      end
      if (m_unl && wctl) begin n_c32 = b_wdata[13]; n_en = b_wdata[7]; n_ua = b_wdata[5]; end
      if (m_unl && wto) n_to = b_wdata;
      m_cnt = n_cnt; m_to = n_to; m_win = n_win; m_pend = n_pend;
      m_c32 = n_c32; m_unl = n_unl; m_rcs = n_rcs; m_en = n_en; m_ua = n_ua;
      m_fired = n_fired; m_rst = n_rst;
    end
  end

  // R9: reset request compared with the reference on every clock
  always @(negedge clk) begin
    if (cmp_en && !done) begin
      nchk++;
      if (rst_req !== m_rst) begin
        nfail++;
        $display("FAIL R9 per-clock rst_req: got %b expected %b", rst_req, m_rst);
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [3:0] a, input logic [31:0] exp, input string tag);
    b_addr = a; b_rd = 1;
    #1;
    chk(tag, rdata, exp);
    b_rd = 0;
  endtask

  task automatic bw(input logic [3:0] a, input logic [31:0] d);
    b_addr = a; b_wdata = d; b_wr = 1;
    @(negedge clk);
    b_wr = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tk(input int n);
    b_tick = 1;
    repeat (n) @(negedge clk);
    b_tick = 0;
  endtask

  task automatic do_reset();
    cmp_en = 0;
    rst_n = 0;
    idle(4);
    rst_n = 1;
    idle(4);
    cmp_en = 1;
  endtask

  initial begin
    b_addr = 0; b_wdata = 0; b_wr = 0; b_rd = 0; b_tick = 0; rst_n = 0;
    @(negedge clk);
    do_reset();
    rd(4'h0, 32'h20, "R1 ctrl after reset");
    rd(4'h8, TMAX, "R1 timeout after reset");
    rd(4'h4, 0, "R1 counter after reset");
    chk("R1 rst_req after reset", {31'd0, rst_req}, 0);
    b_addr = 4'h0; #1; chk("R10 read strobe low", rdata, 0);
    rd(4'hC, 0, "R10 unmapped offset");

    bw(4'h8, 5); bw(4'h0, 32'h20A0); idle(1);
    rd(4'h8, TMAX, "R5 locked timeout write ignored");
    rd(4'h0, 32'h20, "R5 locked ctrl write ignored");
    bw(4'h4, 32'h1234); idle(1);
    rd(4'h4, 0, "R4 plain counter write ignored");

    bw(4'h4, 32'hC520); bw(4'h4, 32'h1111); bw(4'h4, 32'hD928); idle(1);
    rd(4'h0, 32'h20, "R3 wrong second half");
    bw(4'h4, 32'hC520); bw(4'h8, 5); bw(4'h4, 32'hD928); idle(1);
    rd(4'h0, 32'h20, "R3 interleaved write drops half");
    rd(4'h8, TMAX, "R3 interleaved timeout write locked");

    bw(4'h4, 32'hC520); bw(4'h4, 32'hD928); idle(1);
    rd(4'h0, 32'h820, "R3 16-bit unlock");
    bw(4'h8, 20); idle(1);
    rd(4'h8, 20, "R6 timeout loaded while unlocked");
    rd(4'h0, 32'h820, "R6 timeout write keeps unlocked");
    bw(4'h0, 32'h00A0); idle(1);
    rd(4'h0, 32'h4A0, "R6 ctrl write applies and closes");

    tk(5);
    rd(4'h4, 5, "R8 counts ticks while enabled");
    bw(4'h4, 32'hA602); bw(4'h4, 32'hB480); idle(1);
    rd(4'h4, 0, "R4 16-bit refresh");
    tk(3); bw(4'h4, 32'hA602); bw(4'h4, 32'h1234); bw(4'h4, 32'hB480); idle(1);
    rd(4'h4, 3, "R4 broken 16-bit refresh ignored");

    bw(4'h4, 32'hC520); bw(4'h4, 32'hD928); bw(4'h0, 32'h20A0); idle(1);
    rd(4'h0, 32'h24A0, "R6 switch to 32-bit mode");
    tk(4);
    bw(4'h4, 32'hB480A603); idle(1);
    rd(4'h4, 7, "R4 wrong 32-bit refresh ignored");
    bw(4'h4, 32'hB480A602); idle(1);
    rd(4'h4, 0, "R4 32-bit refresh");

    bw(4'h4, 32'hD928C520); idle(1);
    rd(4'h0, 32'h28A0, "R2 32-bit unlock");
    idle(20);
    rd(4'h0, 32'h20A0, "R5 window expired");
    bw(4'h8, 50); idle(1);
    rd(4'h8, 20, "R5 timeout write after expiry ignored");

    bw(4'h4, 32'hB480A602);
    tk(20);
    rd(4'h4, 20, "R9 count reaches timeout");
    chk("R9 no request yet", {31'd0, rst_req}, 0);
    idle(1);
    chk("R9 request pulse", {31'd0, rst_req}, 1);
    idle(1);
    chk("R9 pulse lasts one clock", {31'd0, rst_req}, 0);
    bw(4'h4, 32'hB480A602); tk(3); idle(1);
    rd(4'h4, 20, "R9 counter frozen after firing");

    bw(4'h4, 32'hD928C520); bw(4'h0, 32'h2080); idle(1);
    rd(4'h0, 32'h2480, "R7 update-allow cleared");
    bw(4'h4, 32'hD928C520); idle(1);
    rd(4'h0, 32'h2480, "R7 unlock ignored");
    bw(4'h8, 7); idle(1);
    rd(4'h8, 20, "R7 timeout stays");

    do_reset();
    rd(4'h0, 32'h20, "R1 ctrl after second reset");
    rd(4'h8, TMAX, "R1 timeout after second reset");
    chk("R1 rst_req after second reset", {31'd0, rst_req}, 0);
    bw(4'h4, 32'hC520); bw(4'h4, 32'hD928); idle(1);
    rd(4'h0, 32'h820, "R7 unlock works again after reset");

    idle(2);
    done = 1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      nchk++;
      nfail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end
endmodule